// File: doc/BRIEF.md
# Processor Status Register Write Filter

This block holds the 32-bit processor status word of a system control coprocessor. Software writes do not land verbatim. Each write passes through a static writable-bit mask. When the newer-revision mode flag is set, further rules apply. The three address-segment enable bits are chained, so a low upper-level enable forces the enables below it low. The privilege field rejects its reserved encoding 3. The soft-reset and NMI indicators can be cleared by software but never set by it.

Each accepted write can also refresh a thread-context status register when threading is enabled. The write copies the coprocessor-usable nibble, the extended-ISA enable and the privilege field into that register, together with the current address-space ID, and leaves the rest of it alone. When a write takes away access to an address segment that had been open, the block raises a one-cycle request to flush the translation buffer. A hardware input can set the NMI indicator, and it takes priority over a software write in the same cycle.

Top module: `cop_status_reg`

## Requirements
- R1: After reset, status_q is 0x0018_0000 (soft-reset bit 20 and NMI bit 19 set, all else zero), tcstatus_q is 0 and tlb_flush is 0.
- R2: A write changes only the status bits whose wr_mask bit is 1. Masked bits keep their old value.
- R3: With r6_mode=1, the segment enables are chained. Kernel-segment bit 7 written 0 forces supervisor bit 6 to 0, and bit 6 at 0 forces user bit 5 to 0. With r6_mode=0, the three bits are stored as written.
- R4: With r6_mode=1 and both privilege bits 4:3 writable, a written privilege value of 3 leaves bits 4:3 unchanged. With r6_mode=0, or when only one of the two bits is writable, the value is stored through the mask.
- R5: With r6_mode=1, writing 1 to bit 20 or bit 19 leaves that bit unchanged, and writing 0 clears it. With r6_mode=0, both bits follow the mask.
- R6: One cycle after a write that clears any of status bits 7:5 that was set, tlb_flush is 1 for exactly one cycle. It stays 0 otherwise.
- R7: When a write occurs with mt_en=1, tcstatus_q is updated in the same cycle as status_q. The new status bits 31:28 go to 31:28, bit 24 to 27 and bits 4:3 to 12:11, and asid goes to 7:0. All other tcstatus bits are preserved. With mt_en=0, tcstatus_q is unchanged.
- R8: When nmi_set=1, status bit 19 is 1 in the next cycle, whatever any simultaneous write holds.
- R9: With no write and no nmi_set, status_q holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| wr_mask | input | 32 | Static writable-bit mask |
| r6_mode | input | 1 | Newer-revision write rules enabled |
| mt_en | input | 1 | Threading enabled, mirror into thread-context status |
| asid | input | 8 | Current address-space ID |
| nmi_set | input | 1 | Hardware set of the NMI indicator |
| status_q | output | 32 | Stored status word |
| tcstatus_q | output | 32 | Thread-context status register |
| tlb_flush | output | 1 | One-cycle translation-buffer flush request |

## Verification
All three results are registered once. status_q, tcstatus_q and tlb_flush all show the effect of a write on the clock edge that samples the strobe. The bench drives each write on a falling edge, removes the strobe on the next falling edge, and checks all three outputs there, after exactly one rising edge. It then lets one more idle rising edge pass and checks that tlb_flush has dropped and that status_q has not moved. This makes the one-cycle width of the flush pulse and the hold behaviour part of every vector.

// File: rtl/cpsts_pkg.sv
package cpsts_pkg;
   localparam int unsigned STS_W   = 32;
   localparam int unsigned P_CU    = 28;
   localparam int unsigned P_MX    = 24;
   localparam int unsigned P_SR    = 20;
   localparam int unsigned P_NMI   = 19;
   localparam int unsigned P_KX    = 7;
   localparam int unsigned P_SX    = 6;
   localparam int unsigned P_UX    = 5;
   localparam int unsigned P_KSU   = 3;
   localparam int unsigned T_CU    = 28;
   localparam int unsigned T_MX    = 27;
   localparam int unsigned T_KSU   = 11;
   localparam int unsigned T_ASID  = 0;
   localparam int unsigned CU_W    = 4;
   localparam int unsigned KSU_W   = 2;
   localparam int unsigned SEG_W   = 3;

   typedef logic [STS_W-1:0] word_t;

   typedef struct packed {
      logic [CU_W-1:0]  cu;
      logic             mx;
      logic [KSU_W-1:0] ksu;
   } mirror_t;

   function automatic mirror_t pick_fields(input word_t s);
      mirror_t m;
      m.cu  = s[P_CU +: CU_W];
      m.mx  = s[P_MX];
      m.ksu = s[P_KSU +: KSU_W];
      return m;
   endfunction

   function automatic word_t chain_segments(input word_t v);
      word_t r;
      logic  k, s, u;
      k = v[P_KX];
      s = v[P_SX] & k;
      u = v[P_UX] & s;
      r = v;
      r[P_KX] = k;
      r[P_SX] = s;
      r[P_UX] = u;
      return r;
   endfunction
endpackage

// File: rtl/sts_write_filter.sv
module sts_write_filter
   import cpsts_pkg::*;
#(
   parameter bit HAS_SEG64 = 1'b1
) (
   input  word_t old_q,
   input  word_t wr_data,
   input  word_t wr_mask,
   input  logic  r6_mode,
   output word_t next_val
);
   localparam logic [KSU_W-1:0] KSU_ALL = '1;

   word_t chained;
   word_t eff_val;
   word_t eff_msk;

   generate
      if (HAS_SEG64) begin : g_seg
         assign chained = chain_segments(wr_data);
      end else begin : g_noseg
         assign chained = wr_data;
      end
   endgenerate

   always_comb begin
      eff_val = wr_data;
      eff_msk = wr_mask;
      if (r6_mode) begin
         eff_val = chained;
         if (wr_mask[P_KSU +: KSU_W] == KSU_ALL &&
             wr_data[P_KSU +: KSU_W] == KSU_ALL) begin
            eff_msk[P_KSU +: KSU_W] = '0;
         end
         eff_msk[P_SR]  = wr_mask[P_SR]  & ~wr_data[P_SR];
         eff_msk[P_NMI] = wr_mask[P_NMI] & ~wr_data[P_NMI];
      end
      next_val = (old_q & ~eff_msk) | (eff_val & eff_msk);
   end
endmodule

// File: rtl/sts_flush_detect.sv
module sts_flush_detect
   import cpsts_pkg::*;
#(
   parameter bit HAS_SEG64 = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  word_t old_q,
   input  word_t next_val,
   output logic  flush_q
);
   logic seg_lost;

   generate
      if (HAS_SEG64) begin : g_seg
         assign seg_lost = |(old_q[P_UX +: SEG_W] & ~next_val[P_UX +: SEG_W]);
      end else begin : g_noseg
         assign seg_lost = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_q <= 1'b0;
      end else begin
         flush_q <= wr_en & seg_lost;
      end
   end
endmodule

// File: rtl/sts_tc_mirror.sv
module sts_tc_mirror
   import cpsts_pkg::*;
#(
   parameter int unsigned ASID_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  word_t             next_val,
   input  logic [ASID_W-1:0] asid,
   output word_t             tc_q
);
   localparam word_t ASID_MASK = word_t'((64'd1 << ASID_W) - 64'd1) << T_ASID;
   localparam word_t FIELD_MASK = (word_t'((1 << CU_W) - 1) << T_CU)
                                | (word_t'(1) << T_MX)
                                | (word_t'((1 << KSU_W) - 1) << T_KSU)
                                | ASID_MASK;

   mirror_t fld;
   word_t   fresh;

   always_comb begin
      fld   = pick_fields(next_val);
      fresh = '0;
      fresh[T_CU +: CU_W]    = fld.cu;
      fresh[T_MX]            = fld.mx;
      fresh[T_KSU +: KSU_W]  = fld.ksu;
      fresh[T_ASID +: ASID_W] = asid;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tc_q <= '0;
      end else if (load) begin
         tc_q <= (tc_q & ~FIELD_MASK) | (fresh & FIELD_MASK);
      end
   end
endmodule

// File: rtl/cop_status_reg.sv
module cop_status_reg
   import cpsts_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ASID_W    = 8,
   parameter bit          HAS_SEG64 = 1'b1,
   parameter bit          HAS_MT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] wr_mask,
   input  logic              r6_mode,
   input  logic              mt_en,
   input  logic [ASID_W-1:0] asid,
   input  logic              nmi_set,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] tcstatus_q,
   output logic              tlb_flush
);
   localparam word_t RESET_VAL = (word_t'(1) << P_SR) | (word_t'(1) << P_NMI);

   generate
      if (DATA_W != STS_W) begin : g_bad_width
         $error("cop_status_reg: DATA_W must equal the status word width");
      end
      if (ASID_W < 1 || ASID_W > 8) begin : g_bad_asid
         $error("cop_status_reg: ASID_W must lie in 1..8");
      end
   endgenerate

   word_t sts_r;
   word_t next_val;
   word_t tc_w;

   sts_write_filter #(.HAS_SEG64(HAS_SEG64)) filt_i (
      .old_q    (sts_r),
      .wr_data  (wr_data),
      .wr_mask  (wr_mask),
      .r6_mode  (r6_mode),
      .next_val (next_val)
   );

   sts_flush_detect #(.HAS_SEG64(HAS_SEG64)) flush_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .old_q    (sts_r),
      .next_val (next_val),
      .flush_q  (tlb_flush)
   );

   generate
      if (HAS_MT) begin : g_mt
         sts_tc_mirror #(.ASID_W(ASID_W)) mirror_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (wr_en & mt_en),
            .next_val (next_val),
            .asid     (asid),
            .tc_q     (tc_w)
         );
      end else begin : g_nomt
         assign tc_w = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_r <= RESET_VAL;
      end else begin
         if (wr_en) begin
            sts_r <= next_val;
         end
         if (nmi_set) begin
            sts_r[P_NMI] <= 1'b1;
         end
      end
   end

   assign status_q   = sts_r;
   assign tcstatus_q = tc_w;
endmodule

// File: rtl/cop_status_chk.sv
module cop_status_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ASID_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] wr_mask,
   input logic              r6_mode,
   input logic              mt_en,
   input logic [ASID_W-1:0] asid,
   input logic              nmi_set,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] tcstatus_q,
   input logic              tlb_flush
);
   p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !nmi_set) |=> (((status_q ^ $past(status_q)) & ~$past(wr_mask)) == '0));

   p_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && r6_mode && wr_mask[7:5] == 3'b111) |=>
         ((!status_q[6] || status_q[7]) && (!status_q[5] || status_q[6])));

   p_ksu_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && r6_mode && wr_mask[4:3] == 2'b11 && wr_data[4:3] == 2'b11) |=>
         $stable(status_q[4:3]));

   p_sr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && r6_mode && wr_data[20]) |=> $stable(status_q[20]));

   p_flush_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !tlb_flush);

   p_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mt_en) |=> (tcstatus_q[31:28] == status_q[31:28] &&
                            tcstatus_q[27] == status_q[24] &&
                            tcstatus_q[12:11] == status_q[4:3] &&
                            tcstatus_q[ASID_W-1:0] == $past(asid)));

   p_nmi_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_set |=> status_q[19]);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !nmi_set) |=> $stable(status_q));
endmodule

bind cop_status_reg cop_status_chk #(.DATA_W(DATA_W), .ASID_W(ASID_W)) chk_i (.*);

// File: tb/cop_status_reg_tb_top.sv
module cop_status_reg_tb_top;
   localparam int NV = 10;
   localparam logic [31:0] FULL = 32'hFFFF_FFFF;

   localparam logic        V_R6  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
   localparam logic        V_MT  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
   localparam logic [31:0] V_MSK [NV] = '{32'h0000_00FF, FULL, FULL, FULL, FULL, FULL,
                                          32'hFFFF_FFEF, FULL, FULL, 32'h0000_00C0};
   localparam logic [31:0] V_DAT [NV] = '{32'hFFFF_FFFF, 32'hA100_0010, 32'h0018_00E8,
                                          32'h0000_0060, 32'h0000_00A0, 32'h0000_0098,
                                          32'h0000_0098, 32'h0000_0018, 32'h0000_0040,
                                          32'h0000_0000};
   localparam logic [7:0]  V_ASD [NV] = '{8'h00, 8'h5A, 8'h33, 8'h01, 8'h00, 8'h00,
                                          8'h00, 8'h00, 8'h00, 8'h00};
   localparam logic [31:0] E_ST  [NV] = '{32'h0018_00FF, 32'hA100_0010, 32'h0000_00E8,
                                          32'h0000_0000, 32'h0000_0080, 32'h0000_0080,
                                          32'h0000_0088, 32'h0000_0018, 32'h0000_0040,
                                          32'h0000_0000};
   localparam logic [31:0] E_TC  [NV] = '{32'h0000_0000, 32'hA800_105A, 32'h0000_0833,
                                          32'h0000_0001, 32'h0000_0001, 32'h0000_0001,
                                          32'h0000_0001, 32'h0000_0001, 32'h0000_0001,
                                          32'h0000_0001};
   localparam logic        E_FL  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
   localparam string       V_TAG [NV] = '{"R2", "R7", "R5", "R3", "R3", "R4", "R4", "R4", "R3", "R6"};

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [31:0] wr_data;
   logic [31:0] wr_mask;
   logic        r6_mode;
   logic        mt_en;
   logic [7:0]  asid;
   logic        nmi_set;
   logic [31:0] status_q;
   logic [31:0] tcstatus_q;
   logic        tlb_flush;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   cop_status_reg dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_mask(wr_mask), .r6_mode(r6_mode), .mt_en(mt_en), .asid(asid),
      .nmi_set(nmi_set), .status_q(status_q), .tcstatus_q(tcstatus_q),
      .tlb_flush(tlb_flush)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic r6, input logic mt, input logic [31:0] msk,
                           input logic [31:0] dat, input logic [7:0] a, input logic nmi);
      @(negedge clk);
      wr_en = 1'b1; r6_mode = r6; mt_en = mt; wr_mask = msk;
      wr_data = dat; asid = a; nmi_set = nmi;
      @(negedge clk);
      wr_en = 1'b0; nmi_set = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog R9 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] hold;
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_mask = FULL;
      r6_mode = 1'b0; mt_en = 1'b0; asid = '0; nmi_set = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 status", status_q, 32'h0018_0000);
      check("R1 tcstatus", tcstatus_q, 32'h0);
      check("R1 flush", {31'b0, tlb_flush}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         do_write(V_R6[i], V_MT[i], V_MSK[i], V_DAT[i], V_ASD[i], 1'b0);
         check({V_TAG[i], " status"}, status_q, E_ST[i]);
         check({"R7 tcstatus ", V_TAG[i]}, tcstatus_q, E_TC[i]);
         check({"R6 flush ", V_TAG[i]}, {31'b0, tlb_flush}, {31'b0, E_FL[i]});
         hold = status_q;
         @(negedge clk);
         check("R6 flush one cycle", {31'b0, tlb_flush}, 32'h0);
         check("R9 hold", status_q, hold);
      end

      // R8: hardware NMI set beats a write of zero
      do_write(1'b0, 1'b0, FULL, 32'h0000_0000, 8'h00, 1'b1);
      check("R8 nmi wins", status_q, 32'h0008_0000);
      // R5: non-R6 write may set both bits
      do_write(1'b0, 1'b0, FULL, 32'h0018_0000, 8'h00, 1'b0);
      check("R5 non-r6 set", status_q, 32'h0018_0000);
      // R5: R6 write 1 to SR keeps it, write 0 to NMI clears it
      do_write(1'b1, 1'b0, FULL, 32'h0010_0000, 8'h00, 1'b0);
      check("R5 r6 sr keep nmi clear", status_q, 32'h0010_0000);
      // R8: hardware set alone
      @(negedge clk);
      nmi_set = 1'b1;
      @(negedge clk);
      nmi_set = 1'b0;
      check("R8 nmi alone", status_q, 32'h0018_0000);
      check("R7 tcstatus unchanged", tcstatus_q, 32'h0000_0001);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule